// File: doc/BRIEF.md
# Single-Instruction Repeat Sequencer

This block sits between an instruction fetch stage and the execute datapath and gives the processor a hardware repeat of one instruction. A control strobe with a count C arms the sequencer. The next instruction word that is accepted from fetch is issued to the datapath C+1 times in consecutive cycles. The loop counter is set up, the exit is tested and the program counter is held and released entirely in hardware, so the loop costs no cycles beyond the executions themselves. The datapath carries out each issue as a separate execution, so address post-modification inside the repeated instruction progresses on every pass.

Both instruction paths use valid/ready handshakes. When no repeat is running, the block is a zero-latency pass-through: `issue_valid` follows `fetch_valid`, `fetch_ready` follows `issue_ready`, and the word goes through unchanged. While a repeat is running, fetch is stalled and the held word is presented again and again. A low `issue_ready` freezes the issue slot. It does not use up an iteration. The block keeps the program counter, `pc_out`. This is the address of the next word it expects to accept, and the fetch side returns that address as `fetch_pc` together with the word.

Top module: `rptc_repeat_ctrl`

## Requirements
- R1: During and right after reset, `pc_out` equals the parameter `RESET_PC`, no repeat is armed or running, and `rpt_err` is 0.
- R2: When no repeat is running, `issue_valid`, `issue_insn` and `fetch_ready` equal `fetch_valid`, `fetch_insn` and `issue_ready` in the same cycle.
- R3: Each accepted word that does not start a repeat moves `pc_out` to `fetch_pc + 1`, modulo 2^PC_W, in the next cycle.
- R4: A strobe with count C, given when no repeat is armed or running, arms the block. The first word accepted in a later cycle is issued exactly C+1 times, and C = 0 means one issue.
- R5: The issues of a repeated word follow one another with no gap cycle while `issue_ready` is high, and `fetch_ready` stays 0 until the final issue is accepted.
- R6: During a repeat, `pc_out` stays at the address of the repeated word. In the cycle after the final issue is accepted, it becomes that address + 1.
- R7: If `issue_ready` is low during a repeat, `issue_valid` stays 1, `issue_insn` stays unchanged, and no iteration is consumed.
- R8: `issue_rpt` is 1 on every issue of a repeated word and 0 on all other words. `issue_last` is 1 only on the final issue of a repeated word.
- R9: A strobe that arrives while a repeat is armed or running is ignored and leaves the iteration count unchanged. `rpt_err` is 1 for exactly the following cycle.
- R10: The largest count, 2^CNT_W − 1, gives 2^CNT_W issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_valid | input | 1 | Fetch side offers a word |
| fetch_ready | output | 1 | Block accepts the offered word |
| fetch_pc | input | PC_W | Address of the offered word |
| fetch_insn | input | INSN_W | Offered instruction word |
| rpt_strobe | input | 1 | Repeat command, one cycle |
| rpt_count | input | CNT_W | Extra executions for the repeat command |
| issue_valid | output | 1 | Instruction offered to the datapath |
| issue_ready | input | 1 | Datapath takes the instruction |
| issue_insn | output | INSN_W | Instruction word to execute |
| issue_rpt | output | 1 | Issue belongs to a repeated word |
| issue_last | output | 1 | Final issue of a repeated word |
| pc_out | output | PC_W | Address of the next word to accept |
| rpt_err | output | 1 | Ignored nested repeat command, one-cycle pulse |

## Verification
The bench builds the block with PC_W = 8, CNT_W = 4, INSN_W = 16 and RESET_PC = 0xF0. With these values the program counter wraps from 0xFF to 0x00 within the first few dozen instructions. The largest count, 15, which gives 16 issues, can be reached in a short directed run. Randomised stretches of valid, ready and strobe traffic cover stalls in the middle of a repeat, strobes that are ignored while a repeat is armed or running, and count-zero repeats. Across these stretches a behavioural model is compared with the block on every cycle.

// File: rtl/rptc_pkg.sv
package rptc_pkg;

  typedef enum logic [1:0] {
    SEQ_RUN    = 2'd0,
    SEQ_ARMED  = 2'd1,
    SEQ_REPEAT = 2'd2
  } seq_state_e;

endpackage

// File: rtl/rptc_down_counter.sv
module rptc_down_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             is_zero,
  output logic             is_one
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign is_zero = (cnt_q == '0);
  assign is_one  = (cnt_q == ONE);

  // Each consumed iteration removes exactly one from the remaining count (R4)
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |=> (cnt_q == CNT_W'($past(cnt_q) - ONE)));

  // A decrement is never requested on an empty counter (R4)
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !is_zero);

endmodule

// File: rtl/rptc_hold_reg.sv
module rptc_hold_reg #(
  parameter int unsigned INSN_W = 32,
  parameter int unsigned PC_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [INSN_W-1:0] d_insn,
  input  logic [PC_W-1:0]   d_pc,
  output logic [INSN_W-1:0] q_insn,
  output logic [PC_W-1:0]   q_pc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_insn <= '0;
      q_pc   <= '0;
    end else if (capture) begin
      q_insn <= d_insn;
      q_pc   <= d_pc;
    end
  end

  // The held word changes only on a capture (R7)
  assert_hold_only_on_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(q_insn) && $stable(q_pc)));

endmodule

// File: rtl/rptc_seq_fsm.sv
module rptc_seq_fsm
  import rptc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe,
  input  logic       fetch_hs,
  input  logic       issue_hs,
  input  logic       cnt_zero,
  input  logic       cnt_one,
  output seq_state_e state,
  output logic       err
);

  seq_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      SEQ_RUN:    if (strobe) state_d = SEQ_ARMED;
      SEQ_ARMED:  if (fetch_hs) state_d = cnt_zero ? SEQ_RUN : SEQ_REPEAT;
      SEQ_REPEAT: if (issue_hs && cnt_one) state_d = SEQ_RUN;
      default:    state_d = SEQ_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_RUN;
      err   <= 1'b0;
    end else begin
      state <= state_d;
      err   <= strobe && (state != SEQ_RUN);
    end
  end

  // A strobe while busy flags an error in the next cycle (R9)
  assert_busy_strobe_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && state != SEQ_RUN) |=> err);

  // A strobe while busy never restarts the arming (R9)
  assert_busy_strobe_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && state == SEQ_REPEAT && !issue_hs) |=> (state == SEQ_REPEAT));

endmodule

// File: rtl/rptc_repeat_ctrl.sv
module rptc_repeat_ctrl
  import rptc_pkg::*;
#(
  parameter int unsigned INSN_W   = 32,
  parameter int unsigned PC_W     = 16,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned RESET_PC = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [PC_W-1:0]   fetch_pc,
  input  logic [INSN_W-1:0] fetch_insn,
  input  logic              rpt_strobe,
  input  logic [CNT_W-1:0]  rpt_count,
  output logic              issue_valid,
  input  logic              issue_ready,
  output logic [INSN_W-1:0] issue_insn,
  output logic              issue_rpt,
  output logic              issue_last,
  output logic [PC_W-1:0]   pc_out,
  output logic              rpt_err
);

  localparam logic [PC_W-1:0] PC_INIT = PC_W'(RESET_PC);
  localparam logic [PC_W-1:0] PC_ONE  = PC_W'(1);

  seq_state_e        state;
  logic              in_rep, armed;
  logic              fetch_hs, issue_hs;
  logic              cnt_zero, cnt_one, cnt_load, cnt_dec, capture;
  logic [INSN_W-1:0] held_insn;
  logic [PC_W-1:0]   held_pc;
  logic [PC_W-1:0]   pc_q;

  assign in_rep = (state == SEQ_REPEAT);
  assign armed  = (state == SEQ_ARMED);

  // Issue slot: pass-through outside a repeat, held word inside
  assign fetch_ready = in_rep ? 1'b0 : issue_ready;
  assign issue_valid = in_rep ? 1'b1 : fetch_valid;
  assign issue_insn  = in_rep ? held_insn : fetch_insn;
  assign issue_rpt   = in_rep | armed;
  assign issue_last  = in_rep ? cnt_one : (armed & cnt_zero);

  assign fetch_hs = fetch_valid & fetch_ready;
  assign issue_hs = issue_valid & issue_ready;

  assign cnt_load = rpt_strobe & (state == SEQ_RUN);
  assign cnt_dec  = in_rep & issue_hs & ~cnt_one;
  assign capture  = armed & fetch_hs & ~cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= PC_INIT;
    end else if (capture) begin
      pc_q <= fetch_pc;
    end else if (fetch_hs) begin
      pc_q <= fetch_pc + PC_ONE;
    end else if (in_rep && issue_hs && cnt_one) begin
      pc_q <= held_pc + PC_ONE;
    end
  end

  assign pc_out = pc_q;

  rptc_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (rpt_strobe),
    .fetch_hs (fetch_hs),
    .issue_hs (issue_hs),
    .cnt_zero (cnt_zero),
    .cnt_one  (cnt_one),
    .state    (state),
    .err      (rpt_err)
  );

  rptc_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (rpt_count),
    .dec      (cnt_dec),
    .is_zero  (cnt_zero),
    .is_one   (cnt_one)
  );

  rptc_hold_reg #(.INSN_W(INSN_W), .PC_W(PC_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .d_insn  (fetch_insn),
    .d_pc    (fetch_pc),
    .q_insn  (held_insn),
    .q_pc    (held_pc)
  );

  // Plain accepted word steps the program counter (R3)
  assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_hs && !capture) |=> (pc_out == PC_W'($past(fetch_pc) + PC_ONE)));

  // Program counter frozen while iterations remain (R6)
  assert_pc_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rep && !(issue_hs && issue_last)) |=> $stable(pc_out));

  // Stalled repeat keeps offering the same word (R7)
  assert_stall_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rep && !issue_ready) |=> (issue_valid && $stable(issue_insn)));

  // After the final issue the fetch stream resumes (R5, R8)
  assert_last_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_hs && issue_last) |=> !issue_rpt);

  // Fetch is never accepted while the repeat runs (R5)
  assert_no_fetch_in_repeat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (capture) |=> !fetch_ready);

endmodule

// File: tb/rptc_repeat_ctrl_tb.sv
module rptc_repeat_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int INSN_W     = 16;
  localparam int PC_W       = 8;
  localparam int CNT_W      = 4;
  localparam int RESET_PC   = 'hF0;
  localparam int PC_MOD     = 1 << PC_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              fetch_valid = 1'b0;
  logic              fetch_ready;
  logic [PC_W-1:0]   fetch_pc = '0;
  logic [INSN_W-1:0] fetch_insn = '0;
  logic              rpt_strobe = 1'b0;
  logic [CNT_W-1:0]  rpt_count = '0;
  logic              issue_valid;
  logic              issue_ready = 1'b0;
  logic [INSN_W-1:0] issue_insn;
  logic              issue_rpt;
  logic              issue_last;
  logic [PC_W-1:0]   pc_out;
  logic              rpt_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  rptc_repeat_ctrl #(
    .INSN_W(INSN_W), .PC_W(PC_W), .CNT_W(CNT_W), .RESET_PC(RESET_PC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_pc(fetch_pc), .fetch_insn(fetch_insn),
    .rpt_strobe(rpt_strobe), .rpt_count(rpt_count),
    .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_insn(issue_insn), .issue_rpt(issue_rpt), .issue_last(issue_last),
    .pc_out(pc_out), .rpt_err(rpt_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int rpt_seen = 0;
  int unsigned seed = 32'h1357_9BDF;

  // Behavioural reference state: 0 run, 1 armed, 2 repeating
  int m_mode = 0, m_cnt = 0, m_pc = RESET_PC, m_hpc = 0, m_err = 0;
  int m_hinsn = 0;

  function automatic int mem_word(int pc);
    return (pc * 'h9E37 + 'h1234) % (1 << INSN_W);
  endfunction

  function automatic int unsigned next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cycle(bit fv, bit ir, bit stb, int cnt);
    int e_fr, e_iv, e_ii, e_rpt, e_last, fhs, ihs;
    string rq;
    @(negedge clk);
    fetch_valid = fv;
    issue_ready = ir;
    rpt_strobe  = stb;
    rpt_count   = CNT_W'(cnt);
    fetch_pc    = PC_W'(m_pc);
    fetch_insn  = INSN_W'(mem_word(m_pc));
    #1;
    if (m_mode == 2) begin
      e_fr = 0; e_iv = 1; e_ii = m_hinsn; e_rpt = 1; e_last = (m_cnt == 1);
      rq = ir ? "R5" : "R7";
    end else begin
      e_fr = ir; e_iv = fv; e_ii = mem_word(m_pc); e_rpt = (m_mode == 1);
      e_last = (m_mode == 1 && m_cnt == 0);
      rq = "R2";
    end
    check(rq, "fetch_ready", fetch_ready, e_fr);
    check(rq, "issue_valid", issue_valid, e_iv);
    if (e_iv) check(rq, "issue_insn", issue_insn, e_ii);
    check((m_mode == 2) ? "R6" : "R3", "pc_out", pc_out, m_pc);
    check("R8", "issue_rpt", issue_rpt, e_rpt);
    check("R8", "issue_last", issue_last, e_last);
    check("R9", "rpt_err", rpt_err, m_err);
    if (issue_valid && issue_ready && issue_rpt) rpt_seen++;
    fhs = (m_mode != 2) && fv && ir;
    ihs = e_iv && ir;
    @(posedge clk);
    m_err = stb && (m_mode != 0);
    case (m_mode)
      0: begin
        if (stb) begin m_mode = 1; m_cnt = cnt; end
        if (fhs) m_pc = (m_pc + 1) % PC_MOD;
      end
      1: if (fhs) begin
        if (m_cnt == 0) begin
          m_mode = 0; m_pc = (m_pc + 1) % PC_MOD;
        end else begin
          m_mode = 2; m_hinsn = mem_word(m_pc); m_hpc = m_pc;
        end
      end
      default: if (ihs) begin
        if (m_cnt == 1) begin
          m_mode = 0; m_pc = (m_hpc + 1) % PC_MOD;
        end else m_cnt = m_cnt - 1;
      end
    endcase
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle(1, 1, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    // R1: reset values
    check("R1", "pc_out in reset", pc_out, RESET_PC);
    check("R1", "rpt_err in reset", rpt_err, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "pc_out after reset", pc_out, RESET_PC);
    check("R1", "issue_rpt after reset", issue_rpt, 0);

    // R2, R3: plain stream crossing the 0xFF -> 0x00 wrap
    run(24);
    cycle(0, 1, 0, 0);
    cycle(1, 0, 0, 0);

    // R4: count 5 gives six issues; word accepted with the strobe is not repeated
    rpt_seen = 0;
    cycle(1, 1, 1, 5);
    run(10);
    check("R4", "executions for count 5", rpt_seen, 6);

    // R4: count 0 gives one issue
    rpt_seen = 0;
    cycle(0, 1, 1, 0);
    run(4);
    check("R4", "executions for count 0", rpt_seen, 1);

    // R10: largest count
    rpt_seen = 0;
    cycle(0, 1, 1, 15);
    run(22);
    check("R10", "executions for max count", rpt_seen, 16);

    // R7: stalls in the middle of a repeat do not consume iterations
    rpt_seen = 0;
    cycle(0, 1, 1, 3);
    for (int i = 0; i < 16; i++) cycle(1, i % 3 == 0, 0, 0);
    run(4);
    check("R7", "executions with stalls", rpt_seen, 4);

    // R9: strobes while armed and while repeating are ignored
    rpt_seen = 0;
    cycle(0, 1, 1, 2);
    cycle(0, 1, 1, 9);
    cycle(1, 1, 0, 0);
    cycle(1, 1, 1, 7);
    run(8);
    check("R9", "executions despite nested strobes", rpt_seen, 3);

    // Mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = next_rand();
      cycle(r[0] | r[1], r[2] | r[3], (r[15:8] % 11) == 0, int'(r[23:20]));
    end
    run(40);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule